// File: doc/BRIEF.md
# Two-Level Prefetch Degree Throttle

This block owns the prefetch degree of every core that shares a last-level cache and a memory controller. Once per sampling interval it turns each core's interval counters into a new degree. The counters are prefetch accuracy, bandwidth consumed by that core's prefetcher, bandwidth requested by the other cores, and shared-cache pollution charged to that prefetcher.

The work is split into two levels. A per-core local stage looks only at its own accuracy and proposes to step up, step down or hold. A global stage then checks the interference metrics for that core. It passes the proposal through, or forces a step down when the prefetcher is polluting the shared cache and also using heavy bandwidth while other cores are starved for it. The final decision moves the core's degree one step along 1, 2, 4, 8, 16, and the degree saturates at both ends.

In the cycle whose closing edge samples the counters, the block raises a clear strobe, so the counter collection logic restarts its interval at that same edge.

Top module: `pf_throttle_ctrl`

## Requirements
- R1: During and after reset every core's degree is 2^RESET_LEVEL (4 with defaults), and `cnt_clr_o` is low in the first cycle after reset is released.
- R2: `cnt_clr_o` is high for exactly one cycle in every INTERVAL cycles. The first pulse is in cycle INTERVAL after reset release, and the counters and thresholds are sampled at the rising edge that ends that cycle.
- R3: A core's degree changes only at a sampling edge, and never by more than one step.
- R4: If a core's accuracy count is at or above `acc_hi_thr_i` and no override applies, its degree doubles at the sampling edge.
- R5: If a core's accuracy count is below `acc_lo_thr_i`, its degree halves at the sampling edge.
- R6: If a core's accuracy count is at or above `acc_lo_thr_i` but below `acc_hi_thr_i`, and no override applies, its degree is held.
- R7: If pollution ≥ `pol_thr_i`, own bandwidth ≥ `bw_thr_i` and others' bandwidth need ≥ `bwno_thr_i` all hold for a core, its degree halves at the sampling edge, even when its accuracy is high.
- R8: If any one of the three override comparisons fails, the local proposal is applied unchanged.
- R9: The degree never goes above 16 or below 1. A step up at 16 leaves 16, and a step down at 1 leaves 1.
- R10: Each core's degree depends only on that core's own counters. Core i's counters and degree occupy slice i of each packed vector (bits [i*CNT_W +: CNT_W] for counters and [i*5 +: 5] for the degree). The degree is encoded one-hot as its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_cnt_i | input | NUM_CORES*CNT_W | Per-core prefetch accuracy count |
| bw_cnt_i | input | NUM_CORES*CNT_W | Per-core bandwidth used by that prefetcher |
| bwno_cnt_i | input | NUM_CORES*CNT_W | Per-core bandwidth needed by the other cores |
| pol_cnt_i | input | NUM_CORES*CNT_W | Per-core pollution charged to that prefetcher |
| acc_hi_thr_i | input | CNT_W | Accuracy level for a step-up proposal |
| acc_lo_thr_i | input | CNT_W | Accuracy level below which a step down is proposed |
| bw_thr_i | input | CNT_W | High own-bandwidth threshold |
| bwno_thr_i | input | CNT_W | High others'-bandwidth threshold |
| pol_thr_i | input | CNT_W | High pollution threshold |
| cnt_clr_o | output | 1 | Interval end, clears the counters |
| degree_o | output | NUM_CORES*NUM_LEVELS | Per-core one-hot prefetch degree |

## Verification
The bench drives the degrees into both saturation points. A design without clamping would wrap to a zero or out-of-range degree there. It drives a core with high accuracy and all three interference metrics high, where a design that trusts the local proposal would keep raising the degree. It also drives a case where only two of the three metrics are high, where a design that overrides too eagerly would throttle down. Every cycle is compared against a behavioural model, which exposes a degree that moves off the sampling edge, a misaligned clear strobe, or a change that leaks between cores.

// File: rtl/pf_throttle_pkg.sv
package pf_throttle_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } pf_dec_e;
endpackage

// File: rtl/pf_interval_timer.sv
module pf_interval_timer #(
  parameter int INTERVAL = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pf_local_ctrl.sv
module pf_local_ctrl
  import pf_throttle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] acc_i,
  input  logic [CNT_W-1:0] hi_thr_i,
  input  logic [CNT_W-1:0] lo_thr_i,
  output pf_dec_e          dec_o
);
  always_comb begin
    if (acc_i < lo_thr_i)       dec_o = DEC_DOWN;
    else if (acc_i >= hi_thr_i) dec_o = DEC_UP;
    else                        dec_o = DEC_HOLD;
  end
endmodule

// File: rtl/pf_global_ctrl.sv
module pf_global_ctrl
  import pf_throttle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  pf_dec_e          local_dec_i,
  input  logic [CNT_W-1:0] bw_i,
  input  logic [CNT_W-1:0] bwno_i,
  input  logic [CNT_W-1:0] pol_i,
  input  logic [CNT_W-1:0] bw_thr_i,
  input  logic [CNT_W-1:0] bwno_thr_i,
  input  logic [CNT_W-1:0] pol_thr_i,
  output pf_dec_e          dec_o
);
  logic harm;

  // interference needs all three at once
  assign harm  = (pol_i >= pol_thr_i) && (bw_i >= bw_thr_i) && (bwno_i >= bwno_thr_i);
  assign dec_o = harm ? DEC_DOWN : local_dec_i;
endmodule

// File: rtl/pf_degree_reg.sv
module pf_degree_reg
  import pf_throttle_pkg::*;
#(
  parameter int NUM_LEVELS  = 5,
  parameter int RESET_LEVEL = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  pf_dec_e               dec_i,
  output logic [NUM_LEVELS-1:0] degree_o
);
  localparam int LW = $clog2(NUM_LEVELS);
  localparam logic [LW-1:0] MAX_LVL = LW'(NUM_LEVELS - 1);
  localparam logic [LW-1:0] RST_LVL = LW'(RESET_LEVEL);

  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= RST_LVL;
    end else if (tick_i) begin
      if (dec_i == DEC_UP && lvl_q != MAX_LVL)  lvl_q <= lvl_q + 1'b1;
      else if (dec_i == DEC_DOWN && lvl_q != '0) lvl_q <= lvl_q - 1'b1;
    end
  end

  assign degree_o = NUM_LEVELS'(1) << lvl_q;

  a_r9_level_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= MAX_LVL);
  a_r3_stable_off_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lvl_q));
  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dec_i == DEC_UP && lvl_q != MAX_LVL) |=> lvl_q == $past(lvl_q) + 1'b1);
  a_r9_hold_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dec_i == DEC_UP && lvl_q == MAX_LVL) |=> lvl_q == MAX_LVL);
endmodule

// File: rtl/pf_throttle_ctrl.sv
module pf_throttle_ctrl
  import pf_throttle_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int CNT_W       = 16,
  parameter int NUM_LEVELS  = 5,
  parameter int RESET_LEVEL = 2,
  parameter int INTERVAL    = 256
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CORES*CNT_W-1:0]       acc_cnt_i,
  input  logic [NUM_CORES*CNT_W-1:0]       bw_cnt_i,
  input  logic [NUM_CORES*CNT_W-1:0]       bwno_cnt_i,
  input  logic [NUM_CORES*CNT_W-1:0]       pol_cnt_i,
  input  logic [CNT_W-1:0]                 acc_hi_thr_i,
  input  logic [CNT_W-1:0]                 acc_lo_thr_i,
  input  logic [CNT_W-1:0]                 bw_thr_i,
  input  logic [CNT_W-1:0]                 bwno_thr_i,
  input  logic [CNT_W-1:0]                 pol_thr_i,
  output logic                             cnt_clr_o,
  output logic [NUM_CORES*NUM_LEVELS-1:0]  degree_o
);
  logic tick;

  pf_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign cnt_clr_o = tick;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pf_dec_e local_dec, final_dec;
    logic [CNT_W-1:0] acc, bw, bwno, pol;
    logic [NUM_LEVELS-1:0] deg;

    assign acc  = acc_cnt_i [c*CNT_W +: CNT_W];
    assign bw   = bw_cnt_i  [c*CNT_W +: CNT_W];
    assign bwno = bwno_cnt_i[c*CNT_W +: CNT_W];
    assign pol  = pol_cnt_i [c*CNT_W +: CNT_W];

    pf_local_ctrl #(.CNT_W(CNT_W)) u_local (
      .acc_i    (acc),
      .hi_thr_i (acc_hi_thr_i),
      .lo_thr_i (acc_lo_thr_i),
      .dec_o    (local_dec)
    );

    pf_global_ctrl #(.CNT_W(CNT_W)) u_global (
      .local_dec_i (local_dec),
      .bw_i        (bw),
      .bwno_i      (bwno),
      .pol_i       (pol),
      .bw_thr_i    (bw_thr_i),
      .bwno_thr_i  (bwno_thr_i),
      .pol_thr_i   (pol_thr_i),
      .dec_o       (final_dec)
    );

    pf_degree_reg #(.NUM_LEVELS(NUM_LEVELS), .RESET_LEVEL(RESET_LEVEL)) u_deg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .dec_i    (final_dec),
      .degree_o (deg)
    );

    assign degree_o[c*NUM_LEVELS +: NUM_LEVELS] = deg;

    a_r7_forced_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_clr_o && pol >= pol_thr_i && bw >= bw_thr_i && bwno >= bwno_thr_i && deg != 1)
      |=> deg == ($past(deg) >> 1));
    a_r5_low_acc_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_clr_o && acc < acc_lo_thr_i && deg != 1) |=> deg == ($past(deg) >> 1));
    a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(deg) == 1);
  end
endmodule

// File: tb/test_pf_throttle_ctrl.sv
module test_pf_throttle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int CW  = 8;
  localparam int NL  = 5;
  localparam int RL  = 2;
  localparam int IV  = 8;

  logic clk = 0, rst_n = 0;
  logic [N*CW-1:0] acc_v, bw_v, bwno_v, pol_v;
  logic [CW-1:0] acc_hi = 80, acc_lo = 40, bw_t = 50, bwno_t = 50, pol_t = 30;
  logic cnt_clr;
  logic [N*NL-1:0] degree;

  int acc_a [N], bw_a [N], bwno_a [N], pol_a [N];
  int ref_lvl [N];
  int ref_t;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc_v [i*CW +: CW] = CW'(acc_a[i]);
      bw_v  [i*CW +: CW] = CW'(bw_a[i]);
      bwno_v[i*CW +: CW] = CW'(bwno_a[i]);
      pol_v [i*CW +: CW] = CW'(pol_a[i]);
    end
  end

  pf_throttle_ctrl #(.NUM_CORES(N), .CNT_W(CW), .NUM_LEVELS(NL), .RESET_LEVEL(RL),
                     .INTERVAL(IV)) i_pf_throttle_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_cnt_i(acc_v), .bw_cnt_i(bw_v), .bwno_cnt_i(bwno_v), .pol_cnt_i(pol_v),
    .acc_hi_thr_i(acc_hi), .acc_lo_thr_i(acc_lo), .bw_thr_i(bw_t),
    .bwno_thr_i(bwno_t), .pol_thr_i(pol_t),
    .cnt_clr_o(cnt_clr), .degree_o(degree)
  );

  // behavioural reference: degree as a plain integer
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_t = 0;
      for (int i = 0; i < N; i++) ref_lvl[i] = RL;
    end else begin
      if (ref_t == IV - 1) begin
        for (int i = 0; i < N; i++) begin
          int step;
          if (acc_a[i] < acc_lo) step = -1;
          else if (acc_a[i] >= acc_hi) step = 1;
          else step = 0;
          if (pol_a[i] >= pol_t && bw_a[i] >= bw_t && bwno_a[i] >= bwno_t) step = -1;
          ref_lvl[i] = ref_lvl[i] + step;
          if (ref_lvl[i] > NL - 1) ref_lvl[i] = NL - 1;
          if (ref_lvl[i] < 0) ref_lvl[i] = 0;
        end
      end
      ref_t = (ref_t + 1) % IV;
    end
  end

  function automatic int deg_of(int c);
    return int'(degree[c*NL +: NL]);
  endfunction

  // per-cycle comparison (R2, R3, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cnt_clr !== (ref_t == IV - 1)) begin
        failures++;
        $display("FAIL R2 clear strobe actual=%0b expected=%0b", cnt_clr, (ref_t == IV - 1));
      end
      for (int i = 0; i < N; i++) begin
        checks++;
        if (deg_of(i) != (1 << ref_lvl[i])) begin
          failures++;
          $display("FAIL R3 R10 core%0d degree actual=%0d expected=%0d", i, deg_of(i), 1 << ref_lvl[i]);
        end
      end
    end
  end

  task automatic chk(string req, int c, int exp);
    checks++;
    if (deg_of(c) != exp) begin
      failures++;
      $display("FAIL %s core%0d degree actual=%0d expected=%0d", req, c, deg_of(c), exp);
    end
  endtask

  task automatic set_core(int c, int a, int b, int bn, int p);
    acc_a[c] = a; bw_a[c] = b; bwno_a[c] = bn; pol_a[c] = p;
  endtask

  task automatic run_intervals(int n);
    repeat (n * IV) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    set_core(0, 90, 10, 10, 10);   // high acc, no harm
    set_core(1, 20, 10, 10, 10);   // low acc
    set_core(2, 60, 10, 10, 10);   // mid acc
    set_core(3, 95, 60, 70, 40);   // high acc, all harm high
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) chk("R1", i, 4);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (cnt_clr !== 1'b0) begin
      failures++;
      $display("FAIL R1 clear after reset actual=%0b expected=0", cnt_clr);
    end
    repeat (IV - 2) @(negedge clk);
    checks++;
    if (cnt_clr !== 1'b1) begin
      failures++;
      $display("FAIL R2 first strobe actual=%0b expected=1", cnt_clr);
    end
    chk("R3", 0, 4);
    @(negedge clk);
    chk("R4", 0, 8);
    chk("R5", 1, 2);
    chk("R6", 2, 4);
    chk("R7", 3, 2);
    run_intervals(4);
    chk("R9", 0, 16);
    chk("R9", 1, 1);
    chk("R6", 2, 4);
    chk("R7", 3, 1);
    // two of three harm metrics only: local proposal stands
    set_core(3, 95, 60, 10, 40);
    set_core(1, 85, 10, 10, 10);
    set_core(2, 60, 60, 60, 10);
    run_intervals(1);
    chk("R8", 3, 2);
    chk("R10", 1, 2);
    chk("R9", 0, 16);
    chk("R8", 2, 4);
    // low acc with override passes down unchanged; boundary at thresholds
    set_core(0, 80, 50, 50, 29);
    set_core(1, 40, 10, 10, 10);
    set_core(2, 39, 50, 50, 30);
    run_intervals(1);
    chk("R4", 0, 16);
    chk("R6", 1, 2);
    chk("R7", 2, 2);
    set_core(0, 80, 50, 50, 30);
    run_intervals(1);
    chk("R7", 0, 8);
    done = 1;
    summary();
  end
endmodule